// File: doc/BRIEF.md
# ADC Calibration and Conversion Sequencer

This block times the control pulses for a four-channel ADC whose channels come in two offset-calibration pairs: channels 0 and 1 form one pair, and channels 2 and 3 form the other. After reset the block waits out a settling interval, and during that interval it issues nothing. It then starts two independent schedules.

The first schedule is a conversion strobe, repeating on a period set at an input port. The second is a calibration strobe. Its first instance comes after a long start delay and it then repeats on a fixed calibration period. Each pair has its own calibration strobe, which fires only when the pair's enable bit is set and the chosen compensation channel is the lower channel of that pair.

A conversion strobe that would coincide with a calibration strobe is moved one cycle later. All intervals are parameters counted in clock ticks. The defaults give 100 ms of settling, a 1 s start delay and a 1 s calibration period at 200 MHz, and a test can scale them down.

Top module: `adc_cal_seq`

## Requirements
- R1: While reset is asserted, every output is low.
- R2: `running` rises exactly SETTLE_TICKS clock edges after reset is released and then stays high; no strobe is issued before it rises.
- R3: The calibration schedule fires first SETTLE_TICKS+CAL_FIRST_TICKS edges after reset release, then every CAL_PERIOD_TICKS edges.
- R4: `cal_pulse_01` fires on the calibration schedule only when `pair01_cal_en` is 1 and `pair01_comp_ch` equals 0. `cal_pulse_23` fires only when `pair23_cal_en` is 1 and `pair23_comp_ch` equals 2. The channel fields carry the channel number in binary.
- R5: `conv_pulse` fires first one edge after `running` rises, then every `conv_period` edges; a `conv_period` of 0 issues no conversions.
- R6: Each strobe output is high for exactly one clock cycle at a time.
- R7: A conversion strobe scheduled in the same cycle as an issued calibration strobe appears one cycle later instead. If no calibration strobe is issued, it is not moved.
- R8: `cfg_err_01` is 1 one edge after `pair01_cal_en`=1 with `pair01_comp_ch`≠0, and `cfg_err_23` likewise with `pair23_comp_ch`≠2. A pair whose enable is 0 never raises its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair01_cal_en | input | 1 | Calibration enable, pair 0/1 |
| pair23_cal_en | input | 1 | Calibration enable, pair 2/3 |
| pair01_comp_ch | input | 2 | Compensation channel chosen for pair 0/1 |
| pair23_comp_ch | input | 2 | Compensation channel chosen for pair 2/3 |
| conv_period | input | PER_W | Conversion period in clock ticks (0 = off) |
| running | output | 1 | Settling interval has expired |
| cal_pulse_01 | output | 1 | Calibration strobe, pair 0/1 |
| cal_pulse_23 | output | 1 | Calibration strobe, pair 2/3 |
| conv_pulse | output | 1 | Conversion start strobe |
| cfg_err_01 | output | 1 | Invalid compensation channel, pair 0/1 |
| cfg_err_23 | output | 1 | Invalid compensation channel, pair 2/3 |

## Verification
Every result is registered, so each is due on a fixed edge after reset release: `running` on edge S, the calibration strobes on edges S+F+kP, and conversions on edges S+1+kN, with a collision landing on the following edge. The error flags follow their inputs by one edge. The bench counts edges from reset release and samples all outputs at the falling edge after each rising edge. It compares every output in every cycle against these closed-form schedules, and it also makes explicit checks at the collision edge and at the boundaries of the settling interval.

// File: rtl/adc_cal_seq.sv
`timescale 1ns/1ps
module adc_cal_seq #(
  parameter int unsigned SETTLE_TICKS     = 20_000_000,
  parameter int unsigned CAL_FIRST_TICKS  = 200_000_000,
  parameter int unsigned CAL_PERIOD_TICKS = 200_000_000,
  parameter int unsigned PER_W            = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair01_cal_en,
  input  logic             pair23_cal_en,
  input  logic [1:0]       pair01_comp_ch,
  input  logic [1:0]       pair23_comp_ch,
  input  logic [PER_W-1:0] conv_period,
  output logic             running,
  output logic             cal_pulse_01,
  output logic             cal_pulse_23,
  output logic             conv_pulse,
  output logic             cfg_err_01,
  output logic             cfg_err_23
);
  localparam int unsigned MAX_SF = (SETTLE_TICKS > CAL_FIRST_TICKS) ? SETTLE_TICKS : CAL_FIRST_TICKS;
  localparam int unsigned MAX_T  = (MAX_SF > CAL_PERIOD_TICKS) ? MAX_SF : CAL_PERIOD_TICKS;
  localparam int unsigned CW     = $clog2(MAX_T + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_TICKS - 1);
  localparam logic [CW-1:0] FIRST_LAST  = CW'(CAL_FIRST_TICKS - 1);
  localparam logic [CW-1:0] PERIOD_LAST = CW'(CAL_PERIOD_TICKS - 1);

  logic [CW-1:0]    settle_cnt, cal_cnt;
  logic [PER_W-1:0] conv_cnt;
  logic             conv_pend;

  wire bad01 = pair01_comp_ch != 2'd0;
  wire bad23 = pair23_comp_ch != 2'd2;
  wire go01  = pair01_cal_en & ~bad01;
  wire go23  = pair23_cal_en & ~bad23;

  wire cal_fire  = running && (cal_cnt == '0);
  wire cal01_nx  = cal_fire & go01;
  wire cal23_nx  = cal_fire & go23;
  wire cal_any   = cal01_nx | cal23_nx;
  wire conv_on   = conv_period != '0;
  wire conv_fire = running && conv_on && (conv_cnt == '0);
  wire conv_want = conv_fire | conv_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settle_cnt   <= '0;
      cal_cnt      <= FIRST_LAST;
      conv_cnt     <= '0;
      conv_pend    <= 1'b0;
      running      <= 1'b0;
      cal_pulse_01 <= 1'b0;
      cal_pulse_23 <= 1'b0;
      conv_pulse   <= 1'b0;
      cfg_err_01   <= 1'b0;
      cfg_err_23   <= 1'b0;
    end else begin
      cfg_err_01 <= pair01_cal_en & bad01;
      cfg_err_23 <= pair23_cal_en & bad23;

      if (!running) begin
        if (settle_cnt == SETTLE_LAST) running <= 1'b1;
        else                           settle_cnt <= settle_cnt + 1'b1;
      end else begin
        cal_cnt <= cal_fire ? PERIOD_LAST : cal_cnt - 1'b1;
        if (!conv_on)             conv_cnt <= '0;
        else if (conv_cnt == '0)  conv_cnt <= conv_period - 1'b1;
        else                      conv_cnt <= conv_cnt - 1'b1;
      end

      cal_pulse_01 <= cal01_nx;
      cal_pulse_23 <= cal23_nx;
      conv_pulse   <= conv_want & ~cal_any;
      conv_pend    <= conv_want & cal_any;
    end
  end
endmodule

module adc_cal_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic running,
  input logic cal_pulse_01,
  input logic cal_pulse_23,
  input logic conv_pulse,
  input logic cfg_err_01,
  input logic cfg_err_23
);
  // R2
  running_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
  // R2
  quiet_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !(cal_pulse_01 || cal_pulse_23 || conv_pulse));
  // R6
  cal01_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pulse_01 |=> !cal_pulse_01);
  // R6
  cal23_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pulse_23 |=> !cal_pulse_23);
  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_pulse && (cal_pulse_01 || cal_pulse_23)));
  // R4
  cal01_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pulse_01 |-> !cfg_err_01);
  // R4
  cal23_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pulse_23 |-> !cfg_err_23);
endmodule

bind adc_cal_seq adc_cal_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .running(running),
  .cal_pulse_01(cal_pulse_01), .cal_pulse_23(cal_pulse_23),
  .conv_pulse(conv_pulse), .cfg_err_01(cfg_err_01), .cfg_err_23(cfg_err_23)
);

// File: tb/adc_cal_seq_tb.sv
`timescale 1ns/1ps
module adc_cal_seq_tb;
  localparam int S = 10, F = 40, P = 25, W = 130;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en01 = 0, en23 = 0;
  logic [1:0] ch01 = 0, ch23 = 0;
  logic [15:0] per = 0;
  logic running, cp01, cp23, cvp, er01, er23;
  int cyc = 0, vectors = 0, fails = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  adc_cal_seq #(.SETTLE_TICKS(S), .CAL_FIRST_TICKS(F), .CAL_PERIOD_TICKS(P), .PER_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .pair01_cal_en(en01), .pair23_cal_en(en23),
    .pair01_comp_ch(ch01), .pair23_comp_ch(ch23), .conv_period(per),
    .running(running), .cal_pulse_01(cp01), .cal_pulse_23(cp23), .conv_pulse(cvp),
    .cfg_err_01(er01), .cfg_err_23(er23));

  task automatic check(string req, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: got %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  function automatic bit ok01(); return en01 && ch01 == 2'd0; endfunction
  function automatic bit ok23(); return en23 && ch23 == 2'd2; endfunction
  function automatic bit cal_nom(int k); return k >= S + F && ((k - S - F) % P) == 0; endfunction
  function automatic bit conv_nom(int k);
    return per != 0 && k >= S + 1 && ((k - S - 1) % per) == 0;
  endfunction
  function automatic bit cal_iss(int k); return cal_nom(k) && (ok01() || ok23()); endfunction
  function automatic bit conv_exp(int k);
    return (conv_nom(k) && !cal_iss(k)) || (k >= 1 && conv_nom(k - 1) && cal_iss(k - 1));
  endfunction

  task automatic restart(bit e01, bit [1:0] c01, bit e23, bit [1:0] c23, int p);
    @(negedge clk); rst_n = 0;
    en01 = e01; ch01 = c01; en23 = e23; ch23 = c23; per = 16'(p);
    repeat (3) @(negedge clk);
    // R1
    check("R1", "running", running, 0); check("R1", "cal01", cp01, 0);
    check("R1", "cal23", cp23, 0); check("R1", "conv", cvp, 0);
    check("R1", "err01", er01, 0); check("R1", "err23", er23, 0);
    rst_n = 1;
  endtask

  task automatic run_window(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R2", "running", running, cyc >= S);
      check("R3/R4", "cal01", cp01, cal_nom(cyc) && ok01());
      check("R3/R4", "cal23", cp23, cal_nom(cyc) && ok23());
      check("R5/R7", "conv", cvp, conv_exp(cyc));
      check("R8", "err01", er01, en01 && ch01 != 0);
      check("R8", "err23", er23, en23 && ch23 != 2);
      if (cyc == S - 1) check("R2", "running before settle", running, 0);
      if (cyc == S) check("R2", "running at settle", running, 1);
      if (cyc == S + F) check("R3", "first cal", cp01 | cp23, ok01() | ok23());
      if (cyc == S + F + 1) check("R6", "cal width", cp01 | cp23, 0);
    end
  endtask

  task automatic t_reset_only();
    restart(1, 0, 1, 2, 13);
  endtask

  task automatic t_both_pairs();
    restart(1, 0, 1, 2, 13);
    run_window(S + F - 1);
    @(negedge clk);
    // R7: conversion due on edge 50 collides with calibration
    check("R7", "conv held at collision", cvp, 0);
    check("R3", "cal01 at collision", cp01, 1);
    @(negedge clk);
    check("R7", "conv one cycle late", cvp, 1);
    run_window(W - S - F - 1);
  endtask

  task automatic t_bad_channels();
    restart(1, 1, 1, 2, 13);
    run_window(W);
    restart(0, 2, 1, 3, 13);
    run_window(S + F - 1);
    @(negedge clk);
    // R4 and R7: no calibration issued, conversion not moved
    check("R4", "cal23 blocked", cp23, 0);
    check("R7", "conv not moved", cvp, 1);
    check("R8", "err01 disabled pair", er01, 0);
    check("R8", "err23 bad channel", er23, 1);
    run_window(W - S - F);
  endtask

  task automatic t_conv_off();
    restart(1, 0, 0, 0, 0);
    run_window(W);
    restart(0, 0, 1, 2, 1);
    run_window(W);
  endtask

  initial begin
    t_reset_only();
    t_both_pairs();
    t_bad_channels();
    t_conv_off();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired at cycle %0d: got hang expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule